// File: doc/BRIEF.md
# Queue Head Overlay Update Unit

This block holds the working (overlay) copy of one USB host controller queue head. When a new transfer descriptor is promoted into the queue head, the unit merges the descriptor into the overlay. Each field has its own rule: some are copied from the descriptor, some keep their current overlay value, some are cleared, and the NAK retry counter is reloaded. Between overlays, a split-transaction scheduler may write the split-tracking fields through a small update port. When the queue advances, the error count is returned on a write-back path.

The unit also keeps the endpoint's NAK retry counter. The counter steps down on every NAK or NYET handshake and stops at zero. It is reloaded from the queue head's reload limit at two points. The first is on every overlay. The second is before the first transaction this endpoint runs after an asynchronous list restart.

Top module: `qh_overlay_unit`

## Requirements
- R1: On `load_i`, the interrupt-on-complete output takes `td_ioc_i` on the next clock, whatever its previous value.
- R2: On `load_i`, the data toggle takes `td_toggle_i` when `dtc_i` is 1. When `dtc_i` is 0, it keeps its current overlay value.
- R3: On `load_i`, the 2-bit error count takes `td_cerr_i`. One cycle after `advance_i`, `wb_valid_o` pulses high and `wb_cerr_o` carries the error count that was in the overlay when `advance_i` was sampled.
- R4: The ping/error bit is bit 0 of `ovl_status_o`. On `load_i` with `hs_i`=1 it keeps its overlay value. With `hs_i`=0 it takes `td_status_i[0]`.
- R5: On every `load_i`, the complete-split progress mask and the split frame tag become zero. `split_upd_i` writes `split_cprog_i`, `split_ftag_i` and `split_sbytes_i` into the overlay, but loses to `load_i` in the same cycle.
- R6: On `load_i`, the total-bytes field takes `td_bytes_i`, status bits 7..1 take `td_status_i[7:1]`, and the split byte count takes `td_sbytes_i`.
- R7: When `res_valid_i` is high with `res_code_i` equal to 1 (NAK) or 2 (NYET), the NAK counter drops by one on the next clock. Codes 0 (ACK) and 3 (error) leave it unchanged.
- R8: The NAK counter stops at zero instead of wrapping. `nak_exhausted_o` is high exactly while the counter is zero.
- R9: On `load_i`, the NAK counter takes `rl_i`.
- R10: `restart_i` arms a reload. The next `xact_start_i` loads `rl_i` into the counter and disarms it, so later starts do not reload.
- R11: The order of precedence on the NAK counter is: overlay reload, then restart reload, then decrement.
- R12: After reset, every overlay field, the NAK counter and `wb_valid_o` are zero, and `nak_exhausted_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Overlay strobe: merge descriptor into queue head |
| dtc_i | input | 1 | Toggle control: 1 = take toggle from descriptor |
| hs_i | input | 1 | Endpoint is high speed |
| rl_i | input | NAK_W | NAK counter reload limit |
| td_toggle_i | input | 1 | Descriptor data toggle |
| td_ioc_i | input | 1 | Descriptor interrupt-on-complete |
| td_cerr_i | input | CERR_W | Descriptor error count |
| td_bytes_i | input | BYTES_W | Descriptor total bytes |
| td_status_i | input | STAT_W | Descriptor status byte |
| td_sbytes_i | input | SBYTES_W | Descriptor split byte count |
| split_upd_i | input | 1 | Split scheduler writes tracking fields |
| split_cprog_i | input | CPROG_W | New complete-split progress mask |
| split_ftag_i | input | FTAG_W | New split frame tag |
| split_sbytes_i | input | SBYTES_W | New split byte count |
| res_valid_i | input | 1 | Transaction result valid |
| res_code_i | input | 2 | Result: 0 ACK, 1 NAK, 2 NYET, 3 error |
| restart_i | input | 1 | Asynchronous list restart |
| xact_start_i | input | 1 | A transaction for this endpoint is about to run |
| advance_i | input | 1 | Queue advances: write back error count |
| ovl_toggle_o | output | 1 | Overlay data toggle |
| ovl_ioc_o | output | 1 | Overlay interrupt-on-complete |
| ovl_cerr_o | output | CERR_W | Overlay error count |
| ovl_bytes_o | output | BYTES_W | Overlay total bytes |
| ovl_status_o | output | STAT_W | Overlay status, bit 0 = ping/error |
| ovl_cprog_o | output | CPROG_W | Complete-split progress mask |
| ovl_ftag_o | output | FTAG_W | Split frame tag |
| ovl_sbytes_o | output | SBYTES_W | Split byte count |
| nak_cnt_o | output | NAK_W | NAK retry counter |
| nak_exhausted_o | output | 1 | NAK counter is zero |
| wb_valid_o | output | 1 | Error count write-back valid |
| wb_cerr_o | output | CERR_W | Error count written back |

## Verification
The hardest states to reach are collisions on the NAK counter. These include an overlay and a NAK landing in the same cycle, a restart-armed start together with a NYET, and a restart arriving while a reload is already armed. Fields that keep their value can only be told apart from copied ones after an earlier overlay has left a value that differs from the new descriptor. Directed sequences first drive the counter to zero, then place load, start and result on one edge, and chain overlays with opposite toggle-control and speed settings. A long stretch of biased random strobes then reaches these coincidences repeatedly, while a behavioural model is compared every clock.

// File: rtl/qh_ovl_pkg.sv
package qh_ovl_pkg;

  typedef enum logic [1:0] {
    RES_ACK  = 2'd0,
    RES_NAK  = 2'd1,
    RES_NYET = 2'd2,
    RES_ERR  = 2'd3
  } res_code_e;

  // Handshakes that consume one NAK retry.
  function automatic logic counts_as_nak(input logic [1:0] code);
    return (code == RES_NAK) || (code == RES_NYET);
  endfunction

  // One-bit merge: keep the overlay value or take the descriptor value.
  function automatic logic pick_bit(input logic take_td, input logic ovl, input logic td);
    return take_td ? td : ovl;
  endfunction

endpackage

// File: rtl/qh_ovl_fields.sv
module qh_ovl_fields
  import qh_ovl_pkg::*;
#(
  parameter int CERR_W   = 2,
  parameter int BYTES_W  = 15,
  parameter int STAT_W   = 8,
  parameter int CPROG_W  = 8,
  parameter int FTAG_W   = 5,
  parameter int SBYTES_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                dtc_i,
  input  logic                hs_i,
  input  logic                td_toggle_i,
  input  logic                td_ioc_i,
  input  logic [CERR_W-1:0]   td_cerr_i,
  input  logic [BYTES_W-1:0]  td_bytes_i,
  input  logic [STAT_W-1:0]   td_status_i,
  input  logic [SBYTES_W-1:0] td_sbytes_i,
  input  logic                split_upd_i,
  input  logic [CPROG_W-1:0]  split_cprog_i,
  input  logic [FTAG_W-1:0]   split_ftag_i,
  input  logic [SBYTES_W-1:0] split_sbytes_i,
  output logic                toggle_o,
  output logic                ioc_o,
  output logic [CERR_W-1:0]   cerr_o,
  output logic [BYTES_W-1:0]  bytes_o,
  output logic [STAT_W-1:0]   status_o,
  output logic [CPROG_W-1:0]  cprog_o,
  output logic [FTAG_W-1:0]   ftag_o,
  output logic [SBYTES_W-1:0] sbytes_o
);

  localparam int STAT_HI = STAT_W - 1;

  logic                next_toggle;
  logic                next_ping;
  logic [STAT_W-1:0]   next_status;
  logic                split_write;

  always_comb begin
    next_toggle = pick_bit(dtc_i, toggle_o, td_toggle_i);
    next_ping   = pick_bit(!hs_i, status_o[0], td_status_i[0]);
    next_status = {td_status_i[STAT_HI:1], next_ping};
    split_write = split_upd_i && !load_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle_o <= 1'b0;
      ioc_o    <= 1'b0;
      cerr_o   <= '0;
      bytes_o  <= '0;
      status_o <= '0;
      cprog_o  <= '0;
      ftag_o   <= '0;
      sbytes_o <= '0;
    end else if (load_i) begin
      toggle_o <= next_toggle;
      ioc_o    <= td_ioc_i;
      cerr_o   <= td_cerr_i;
      bytes_o  <= td_bytes_i;
      status_o <= next_status;
      cprog_o  <= '0;
      ftag_o   <= '0;
      sbytes_o <= td_sbytes_i;
    end else if (split_write) begin
      cprog_o  <= split_cprog_i;
      ftag_o   <= split_ftag_i;
      sbytes_o <= split_sbytes_i;
    end
  end

endmodule

// File: rtl/qh_nak_ctr.sv
module qh_nak_ctr
  import qh_ovl_pkg::*;
#(
  parameter int NAK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NAK_W-1:0] rl_i,
  input  logic             restart_i,
  input  logic             xact_start_i,
  input  logic             res_valid_i,
  input  logic [1:0]       res_code_i,
  output logic [NAK_W-1:0] cnt_o,
  output logic             exhausted_o,
  output logic             ev_ovl_reload_o,
  output logic             ev_pass_reload_o,
  output logic             ev_dec_o
);

  localparam logic [NAK_W-1:0] ONE = NAK_W'(1);

  logic armed_q;
  logic nak_seen;

  function automatic logic [NAK_W-1:0] step_down(input logic [NAK_W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  always_comb begin
    nak_seen         = res_valid_i && counts_as_nak(res_code_i);
    ev_ovl_reload_o  = load_i;
    ev_pass_reload_o = !load_i && armed_q && xact_start_i;
    ev_dec_o         = !load_i && !ev_pass_reload_o && nak_seen;
    exhausted_o      = (cnt_o == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (ev_ovl_reload_o || ev_pass_reload_o) cnt_o <= rl_i;
      else if (ev_dec_o)                       cnt_o <= step_down(cnt_o);
      armed_q <= restart_i || (armed_q && !xact_start_i);
    end
  end

endmodule

// File: rtl/qh_cerr_wb.sv
module qh_cerr_wb #(
  parameter int CERR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance_i,
  input  logic [CERR_W-1:0] cerr_i,
  output logic              wb_valid_o,
  output logic [CERR_W-1:0] wb_cerr_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid_o <= 1'b0;
      wb_cerr_o  <= '0;
    end else begin
      wb_valid_o <= advance_i;
      if (advance_i) wb_cerr_o <= cerr_i;
    end
  end

endmodule

// File: rtl/qh_overlay_unit.sv
module qh_overlay_unit #(
  parameter int NAK_W    = 4,
  parameter int CERR_W   = 2,
  parameter int BYTES_W  = 15,
  parameter int STAT_W   = 8,
  parameter int CPROG_W  = 8,
  parameter int FTAG_W   = 5,
  parameter int SBYTES_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                dtc_i,
  input  logic                hs_i,
  input  logic [NAK_W-1:0]    rl_i,
  input  logic                td_toggle_i,
  input  logic                td_ioc_i,
  input  logic [CERR_W-1:0]   td_cerr_i,
  input  logic [BYTES_W-1:0]  td_bytes_i,
  input  logic [STAT_W-1:0]   td_status_i,
  input  logic [SBYTES_W-1:0] td_sbytes_i,
  input  logic                split_upd_i,
  input  logic [CPROG_W-1:0]  split_cprog_i,
  input  logic [FTAG_W-1:0]   split_ftag_i,
  input  logic [SBYTES_W-1:0] split_sbytes_i,
  input  logic                res_valid_i,
  input  logic [1:0]          res_code_i,
  input  logic                restart_i,
  input  logic                xact_start_i,
  input  logic                advance_i,
  output logic                ovl_toggle_o,
  output logic                ovl_ioc_o,
  output logic [CERR_W-1:0]   ovl_cerr_o,
  output logic [BYTES_W-1:0]  ovl_bytes_o,
  output logic [STAT_W-1:0]   ovl_status_o,
  output logic [CPROG_W-1:0]  ovl_cprog_o,
  output logic [FTAG_W-1:0]   ovl_ftag_o,
  output logic [SBYTES_W-1:0] ovl_sbytes_o,
  output logic [NAK_W-1:0]    nak_cnt_o,
  output logic                nak_exhausted_o,
  output logic                wb_valid_o,
  output logic [CERR_W-1:0]   wb_cerr_o
);

  // Internal events brought out by name for the checker.
  logic ev_ovl_reload;
  logic ev_pass_reload;
  logic ev_dec;

  qh_ovl_fields #(
    .CERR_W(CERR_W), .BYTES_W(BYTES_W), .STAT_W(STAT_W),
    .CPROG_W(CPROG_W), .FTAG_W(FTAG_W), .SBYTES_W(SBYTES_W)
  ) u_fields (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .dtc_i(dtc_i), .hs_i(hs_i),
    .td_toggle_i(td_toggle_i), .td_ioc_i(td_ioc_i), .td_cerr_i(td_cerr_i),
    .td_bytes_i(td_bytes_i), .td_status_i(td_status_i), .td_sbytes_i(td_sbytes_i),
    .split_upd_i(split_upd_i), .split_cprog_i(split_cprog_i),
    .split_ftag_i(split_ftag_i), .split_sbytes_i(split_sbytes_i),
    .toggle_o(ovl_toggle_o), .ioc_o(ovl_ioc_o), .cerr_o(ovl_cerr_o),
    .bytes_o(ovl_bytes_o), .status_o(ovl_status_o), .cprog_o(ovl_cprog_o),
    .ftag_o(ovl_ftag_o), .sbytes_o(ovl_sbytes_o)
  );

  qh_nak_ctr #(.NAK_W(NAK_W)) u_nak (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .rl_i(rl_i),
    .restart_i(restart_i), .xact_start_i(xact_start_i),
    .res_valid_i(res_valid_i), .res_code_i(res_code_i),
    .cnt_o(nak_cnt_o), .exhausted_o(nak_exhausted_o),
    .ev_ovl_reload_o(ev_ovl_reload), .ev_pass_reload_o(ev_pass_reload),
    .ev_dec_o(ev_dec)
  );

  qh_cerr_wb #(.CERR_W(CERR_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .advance_i(advance_i), .cerr_i(ovl_cerr_o),
    .wb_valid_o(wb_valid_o), .wb_cerr_o(wb_cerr_o)
  );

endmodule

// File: rtl/qh_overlay_unit_chk.sv
module qh_overlay_unit_chk #(
  parameter int NAK_W  = 4,
  parameter int CERR_W = 2,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              dtc_i,
  input logic              hs_i,
  input logic              td_ioc_i,
  input logic [CERR_W-1:0] td_cerr_i,
  input logic [NAK_W-1:0]  rl_i,
  input logic              advance_i,
  input logic              ovl_toggle_o,
  input logic              ovl_ioc_o,
  input logic [CERR_W-1:0] ovl_cerr_o,
  input logic [STAT_W-1:0] ovl_status_o,
  input logic [7:0]        ovl_cprog_o,
  input logic [4:0]        ovl_ftag_o,
  input logic [NAK_W-1:0]  nak_cnt_o,
  input logic              wb_valid_o,
  input logic [CERR_W-1:0] wb_cerr_o,
  input logic              ev_ovl_reload,
  input logic              ev_pass_reload,
  input logic              ev_dec
);

  p_ioc_inherit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ovl_ioc_o == $past(td_ioc_i));

  p_toggle_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !dtc_i) |=> $stable(ovl_toggle_o));

  p_cerr_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ovl_cerr_o == $past(td_cerr_i));

  p_wb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |=> (wb_valid_o && wb_cerr_o == $past(ovl_cerr_o)));

  p_ping_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && hs_i) |=> $stable(ovl_status_o[0]));

  p_split_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ovl_cprog_o == '0 && ovl_ftag_o == '0));

  p_nak_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dec && nak_cnt_o != '0) |=> nak_cnt_o == $past(nak_cnt_o) - NAK_W'(1));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dec && nak_cnt_o == '0) |=> nak_cnt_o == '0);

  p_ovl_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> nak_cnt_o == $past(rl_i));

  p_pass_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass_reload |=> nak_cnt_o == $past(rl_i));

  p_one_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_ovl_reload, ev_pass_reload, ev_dec}) <= 1);

endmodule

bind qh_overlay_unit qh_overlay_unit_chk #(
  .NAK_W(NAK_W), .CERR_W(CERR_W), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .dtc_i(dtc_i), .hs_i(hs_i),
  .td_ioc_i(td_ioc_i), .td_cerr_i(td_cerr_i), .rl_i(rl_i), .advance_i(advance_i),
  .ovl_toggle_o(ovl_toggle_o), .ovl_ioc_o(ovl_ioc_o), .ovl_cerr_o(ovl_cerr_o),
  .ovl_status_o(ovl_status_o), .ovl_cprog_o(ovl_cprog_o[7:0]),
  .ovl_ftag_o(ovl_ftag_o[4:0]), .nak_cnt_o(nak_cnt_o),
  .wb_valid_o(wb_valid_o), .wb_cerr_o(wb_cerr_o),
  .ev_ovl_reload(ev_ovl_reload), .ev_pass_reload(ev_pass_reload), .ev_dec(ev_dec)
);

// File: tb/test_qh_overlay_unit.sv
`timescale 1ns/1ps
module test_qh_overlay_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic load_i = 0, dtc_i = 0, hs_i = 0, td_toggle_i = 0, td_ioc_i = 0;
  logic [3:0]  rl_i = 0;
  logic [1:0]  td_cerr_i = 0;
  logic [14:0] td_bytes_i = 0;
  logic [7:0]  td_status_i = 0;
  logic [6:0]  td_sbytes_i = 0;
  logic        split_upd_i = 0;
  logic [7:0]  split_cprog_i = 0;
  logic [4:0]  split_ftag_i = 0;
  logic [6:0]  split_sbytes_i = 0;
  logic        res_valid_i = 0;
  logic [1:0]  res_code_i = 0;
  logic        restart_i = 0, xact_start_i = 0, advance_i = 0;

  logic        ovl_toggle_o, ovl_ioc_o, nak_exhausted_o, wb_valid_o;
  logic [1:0]  ovl_cerr_o, wb_cerr_o;
  logic [14:0] ovl_bytes_o;
  logic [7:0]  ovl_status_o, ovl_cprog_o;
  logic [4:0]  ovl_ftag_o;
  logic [6:0]  ovl_sbytes_o;
  logic [3:0]  nak_cnt_o;

  qh_overlay_unit i_qh_overlay_unit (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  bit live = 0;

  // Behavioural reference state
  int m_tog, m_ioc, m_cerr, m_bytes, m_stat, m_cprog, m_ftag, m_sb, m_nak, m_wbv, m_wbc;
  bit m_armed;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tog = 0; m_ioc = 0; m_cerr = 0; m_bytes = 0; m_stat = 0;
      m_cprog = 0; m_ftag = 0; m_sb = 0; m_nak = 0; m_wbv = 0; m_wbc = 0; m_armed = 0;
    end else begin
      int old_cerr;
      bit pass_hit;
      old_cerr = m_cerr;
      pass_hit = m_armed && xact_start_i;
      // NAK counter precedence: overlay, restart pass, decrement
      if (load_i) m_nak = rl_i;
      else if (pass_hit) m_nak = rl_i;
      else if (res_valid_i && (res_code_i == 1 || res_code_i == 2))
        m_nak = (m_nak > 0) ? m_nak - 1 : 0;
      if (restart_i) m_armed = 1;
      else if (xact_start_i) m_armed = 0;
      if (load_i) begin
        if (dtc_i) m_tog = td_toggle_i;
        m_ioc = td_ioc_i;
        m_cerr = td_cerr_i;
        m_bytes = td_bytes_i;
        m_stat = (td_status_i & 8'hFE) | (hs_i ? (m_stat & 1) : (td_status_i & 1));
        m_cprog = 0; m_ftag = 0; m_sb = td_sbytes_i;
      end else if (split_upd_i) begin
        m_cprog = split_cprog_i; m_ftag = split_ftag_i; m_sb = split_sbytes_i;
      end
      m_wbv = advance_i;
      if (advance_i) m_wbc = old_cerr;
    end
  end

  always @(negedge clk) if (live) begin
    chk("R1 ioc", ovl_ioc_o, m_ioc);
    chk("R2 toggle", ovl_toggle_o, m_tog);
    chk("R3 cerr", ovl_cerr_o, m_cerr);
    chk("R3 wb_valid", wb_valid_o, m_wbv);
    if (m_wbv) chk("R3 wb_cerr", wb_cerr_o, m_wbc);
    chk("R4 ping", ovl_status_o[0], m_stat & 1);
    chk("R5 cprog", ovl_cprog_o, m_cprog);
    chk("R5 ftag", ovl_ftag_o, m_ftag);
    chk("R6 status", ovl_status_o, m_stat);
    chk("R6 bytes", ovl_bytes_o, m_bytes);
    chk("R6 sbytes", ovl_sbytes_o, m_sb);
    chk("R7 R9 R10 R11 nak_cnt", nak_cnt_o, m_nak);
    chk("R8 exhausted", nak_exhausted_o, (m_nak == 0));
  end

  task automatic idle();
    load_i = 0; split_upd_i = 0; res_valid_i = 0; restart_i = 0;
    xact_start_i = 0; advance_i = 0;
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_load(bit dtc, bit hs, bit tog, bit ioc, int cerr, int stat, int rl);
    load_i = 1; dtc_i = dtc; hs_i = hs; td_toggle_i = tog; td_ioc_i = ioc;
    td_cerr_i = 2'(cerr); td_status_i = 8'(stat); rl_i = 4'(rl);
    td_bytes_i = 15'($urandom); td_sbytes_i = 7'($urandom);
  endtask

  initial begin
    idle();
    repeat (3) cyc();
    // R12: reset state at the ports
    chk("R12 nak_cnt", nak_cnt_o, 0);
    chk("R12 exhausted", nak_exhausted_o, 1);
    chk("R12 wb_valid", wb_valid_o, 0);
    chk("R12 fields", {ovl_toggle_o, ovl_ioc_o, ovl_cerr_o, ovl_status_o, ovl_cprog_o}, 0);
    rst_n = 1; live = 1;
    cyc();
    // Directed: copy-all load, non-HS takes ping
    do_load(1, 0, 1, 1, 2, 8'hA5, 3); cyc(); idle();
    // R3 write-back
    advance_i = 1; cyc(); idle(); cyc();
    // R7/R8: drain with NAK/NYET, plus ACK/err no effect
    res_valid_i = 1; res_code_i = 0; cyc();
    res_code_i = 3; cyc();
    repeat (2) begin res_code_i = 1; cyc(); res_code_i = 2; cyc(); end
    res_code_i = 1; cyc(); idle(); cyc();
    chk("R8 saturate at zero", nak_cnt_o, 0);
    // R11: load and NAK same edge
    do_load(0, 1, 0, 0, 1, 8'h40, 9); res_valid_i = 1; res_code_i = 1; cyc(); idle(); cyc();
    chk("R11 load beats NAK", nak_cnt_o, 9);
    chk("R2 toggle kept with dtc=0", ovl_toggle_o, 1);
    chk("R4 ping kept on high speed", ovl_status_o[0], 1);
    // R10: restart, NAKs, start reloads once
    rl_i = 6; restart_i = 1; cyc(); idle();
    res_valid_i = 1; res_code_i = 2; cyc(); cyc(); idle();
    xact_start_i = 1; res_valid_i = 1; res_code_i = 1; cyc(); idle(); cyc();
    chk("R10 restart reload", nak_cnt_o, 6);
    res_valid_i = 1; res_code_i = 1; cyc(); idle();
    xact_start_i = 1; cyc(); idle(); cyc();
    chk("R10 only once", nak_cnt_o, 5);
    // R5: split update then load clears; collision load wins
    split_upd_i = 1; split_cprog_i = 8'h3C; split_ftag_i = 5'd17; split_sbytes_i = 7'd9; cyc(); idle(); cyc();
    chk("R5 split write", ovl_cprog_o, 8'h3C);
    do_load(1, 0, 0, 1, 3, 8'h00, 2); split_upd_i = 1; cyc(); idle(); cyc();
    chk("R5 cleared on load", {ovl_cprog_o, ovl_ftag_o}, 0);
    // Random stretch
    for (int i = 0; i < 4000; i++) begin
      load_i = ($urandom % 8) == 0; dtc_i = 1'($urandom); hs_i = 1'($urandom);
      td_toggle_i = 1'($urandom); td_ioc_i = 1'($urandom); td_cerr_i = 2'($urandom);
      td_bytes_i = 15'($urandom); td_status_i = 8'($urandom); td_sbytes_i = 7'($urandom);
      rl_i = 4'($urandom % 5);
      split_upd_i = ($urandom % 4) == 0; split_cprog_i = 8'($urandom);
      split_ftag_i = 5'($urandom); split_sbytes_i = 7'($urandom);
      res_valid_i = 1'($urandom); res_code_i = 2'($urandom);
      restart_i = ($urandom % 16) == 0; xact_start_i = ($urandom % 4) == 0;
      advance_i = ($urandom % 6) == 0;
      cyc();
    end
    idle(); cyc(); cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule